// File: doc/BRIEF.md
# DMA Protected Range Checker

This block screens upstream bus-master requests against a no-DMA window that sits directly below a programmable segment base. It also decides whether a request that is allowed through decodes to DRAM. Each request arrives with its address after translation, a valid strobe and a flag that separates DMA or graphics-aperture traffic from processor-originated streams. The check runs on the translated address and does not depend on any other protection check. A request that translation has already passed is still faulted if it lands in the window.

The window is configured by a base page number, a window size in 4 KB pages and an enable bit. All three may be rewritten while traffic is flowing. A small two-state controller watches the configuration. In `LIM_STEADY` it holds the active limits; the transition `LIM_STEADY -> LIM_STEADY` occurs while the inputs match the last captured copy. When the inputs differ, the transition `LIM_STEADY -> LIM_ARM` registers the new lower limit in a staging stage. The transition `LIM_ARM -> LIM_STEADY` is taken unconditionally and copies the staged limits into the active limits on a single clock edge. Every request is therefore decoded entirely against one limit set, either the old one or the new one, and no in-flight request needs to be flushed.

Responses are registered and appear one cycle after the request. They consist of a fault flag, a DRAM-decode flag and a flag for the fixed legacy video hole.

Top module: `dpr_guard`

## Requirements
- R1: A request with `req_dma`=0 (processor stream) never sets `rsp_fault`.
- R2: With the window active (`cfg_en`=1 and `cfg_size_pg`≠0), a request with `req_dma`=1 whose page number (address bits [ADDR_W-1:12]) lies in [base−size, base) gives `rsp_fault`=1 and `rsp_dram`=0.
- R3: A request whose page lies below the active lower limit and outside the legacy hole gives `rsp_dram`=1 and `rsp_fault`=0, whatever the value of `req_dma`.
- R4: With `cfg_en`=0 or `cfg_size_pg`=0, no request faults, and every page below the base that lies outside the legacy hole decodes to DRAM.
- R5: Byte addresses 0xA0000 through 0xBFFFF give `rsp_legacy`=1 and `rsp_dram`=0. All other addresses give `rsp_legacy`=0.
- R6: A request whose page is at or above the base page gives `rsp_fault`=0 and `rsp_dram`=0.
- R7: A processor request (`req_dma`=0) inside the window decodes to DRAM, unless it falls in the legacy hole.
- R8: When the size exceeds the base, the lower limit clamps to page 0, so every page below the base is protected from DMA.
- R9: `rsp_vld` equals `req_vld` delayed by one cycle. While `rsp_vld`=0, all three flags are 0.
- R10: After a configuration change applied in cycle c and then held, requests presented in cycles c and c+1 are each decoded wholly with either the old limits or the new limits. Requests from cycle c+2 onward use the new limits.
- R11: `rsp_fault` and `rsp_dram` are never 1 in the same cycle.
- R12: During and right after reset, all outputs are 0 and the active window is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_vld | input | 1 | Request valid strobe |
| req_addr | input | ADDR_W | Post-translation byte address |
| req_dma | input | 1 | 1 = DMA or aperture translation, 0 = processor stream |
| cfg_base_pg | input | ADDR_W-12 | Segment base, as a 4 KB page number |
| cfg_size_pg | input | SZ_W | Protected window size in 4 KB pages |
| cfg_en | input | 1 | Window enable |
| rsp_vld | output | 1 | Response valid, one cycle after the request |
| rsp_fault | output | 1 | Request hit the no-DMA window |
| rsp_dram | output | 1 | Request decodes to DRAM |
| rsp_legacy | output | 1 | Request lies in the legacy video hole |

## Verification
A stale or torn active limit shows up at the ports as a fault or DRAM flag on the wrong side of the window boundary. The error appears on the first response after the affected request, which is one cycle later. If the staging state fails to commit, a probe page that changes class between the old and new configuration still reports the old class two cycles after the change. Sweeping every page for both request types, under configurations that cover a disabled window, a zero size, a clamped size and overlap with the legacy hole, exposes any off-by-one at either edge of the window.

// File: rtl/dpr_guard_pkg.sv
package dpr_guard_pkg;

    localparam int PAGE_SHIFT = 12;
    localparam logic [31:0] VGA_HOLE_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_HOLE_HI = 32'h000B_FFFF;

    typedef enum logic [0:0] {
        LIM_STEADY = 1'b0,
        LIM_ARM    = 1'b1
    } lim_state_e;

endpackage

// File: rtl/dpr_limit_ctrl.sv
module dpr_limit_ctrl
    import dpr_guard_pkg::*;
#(
    parameter int PG_W = 8,
    parameter int SZ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] cfg_base_pg,
    input  logic [SZ_W-1:0] cfg_size_pg,
    input  logic            cfg_en,
    output logic [PG_W-1:0] act_lo_pg,
    output logic [PG_W-1:0] act_hi_pg,
    output logic            act_on
);

    localparam int CW = ((PG_W > SZ_W) ? PG_W : SZ_W) + 1;

    lim_state_e      state_q, state_d;

    logic [PG_W-1:0] seen_base;
    logic [SZ_W-1:0] seen_size;
    logic            seen_en;

    logic [PG_W-1:0] stg_lo, stg_hi;
    logic            stg_on;

    logic            cfg_diff;
    logic            new_on;
    logic [CW-1:0]   base_x, size_x;
    logic [PG_W-1:0] new_lo;

    assign cfg_diff = (cfg_base_pg != seen_base) || (cfg_size_pg != seen_size)
                   || (cfg_en != seen_en);

    // Lower limit of the window for the presented configuration
    always_comb begin
        base_x = CW'(cfg_base_pg);
        size_x = CW'(cfg_size_pg);
        new_on = cfg_en && (cfg_size_pg != '0);
        if (!new_on) begin
            new_lo = cfg_base_pg;
        end else if (size_x > base_x) begin
            new_lo = '0;
        end else begin
            new_lo = PG_W'(base_x - size_x);
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LIM_STEADY: if (cfg_diff) state_d = LIM_ARM;
            LIM_ARM:    state_d = LIM_STEADY;
            default:    state_d = LIM_STEADY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LIM_STEADY;
        else        state_q <= state_d;
    end

    // Staging and atomic commit of the limits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_base <= '0;
            seen_size <= '0;
            seen_en   <= 1'b0;
            stg_lo    <= '0;
            stg_hi    <= '0;
            stg_on    <= 1'b0;
            act_lo_pg <= '0;
            act_hi_pg <= '0;
            act_on    <= 1'b0;
        end else begin
            unique case (state_q)
                LIM_STEADY: begin
                    if (cfg_diff) begin
                        seen_base <= cfg_base_pg;
                        seen_size <= cfg_size_pg;
                        seen_en   <= cfg_en;
                        stg_lo    <= new_lo;
                        stg_hi    <= cfg_base_pg;
                        stg_on    <= new_on;
                    end
                end
                LIM_ARM: begin
                    act_lo_pg <= stg_lo;
                    act_hi_pg <= stg_hi;
                    act_on    <= stg_on;
                end
                default: ;
            endcase
        end
    end

    AST_LIM_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        act_lo_pg <= act_hi_pg); // R8

    AST_LIM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LIM_STEADY |=> $stable({act_lo_pg, act_hi_pg, act_on})); // R10

    AST_LIM_ARM_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == LIM_ARM |=> state_q == LIM_STEADY); // R10

    AST_STAGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        stg_lo <= stg_hi); // R8

endmodule

// File: rtl/dpr_req_check.sv
module dpr_req_check
    import dpr_guard_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int PG_W   = ADDR_W - PAGE_SHIFT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_dma,
    input  logic [PG_W-1:0]   act_lo_pg,
    input  logic [PG_W-1:0]   act_hi_pg,
    input  logic              act_on,
    output logic              rsp_vld,
    output logic              rsp_fault,
    output logic              rsp_dram,
    output logic              rsp_legacy
);

    localparam int XW = (ADDR_W > 32) ? ADDR_W : 32;

    logic [PG_W-1:0] req_pg;
    logic [XW-1:0]   addr_x;
    logic            in_win, below_lo, in_hole;
    logic            hit_fault, hit_dram;

    assign req_pg = req_addr[ADDR_W-1:PAGE_SHIFT];
    assign addr_x = XW'(req_addr);

    always_comb begin
        in_hole   = (addr_x >= XW'(VGA_HOLE_LO)) && (addr_x <= XW'(VGA_HOLE_HI));
        below_lo  = req_pg < act_lo_pg;
        in_win    = act_on && (req_pg >= act_lo_pg) && (req_pg < act_hi_pg);
        hit_fault = req_dma && in_win;
        hit_dram  = !in_hole && (below_lo || (!req_dma && in_win));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_vld    <= 1'b0;
            rsp_fault  <= 1'b0;
            rsp_dram   <= 1'b0;
            rsp_legacy <= 1'b0;
        end else begin
            rsp_vld    <= req_vld;
            rsp_fault  <= req_vld && hit_fault;
            rsp_dram   <= req_vld && hit_dram;
            rsp_legacy <= req_vld && in_hole;
        end
    end

    AST_FAULT_DRAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> !rsp_dram); // R11

    AST_CPU_NEVER_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !req_dma |=> !rsp_fault); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld && !rsp_fault && !rsp_dram && !rsp_legacy); // R9

    AST_HOLE_NOT_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_legacy |-> !rsp_dram); // R5

    AST_OFF_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && !act_on |=> !rsp_fault); // R4

    AST_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld && (req_pg >= act_hi_pg) |=> !rsp_fault && !rsp_dram); // R6

endmodule

// File: rtl/dpr_guard.sv
module dpr_guard
    import dpr_guard_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int SZ_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_vld,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_dma,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] cfg_base_pg,
    input  logic [SZ_W-1:0]            cfg_size_pg,
    input  logic                       cfg_en,
    output logic                       rsp_vld,
    output logic                       rsp_fault,
    output logic                       rsp_dram,
    output logic                       rsp_legacy
);

    localparam int PG_W = ADDR_W - PAGE_SHIFT;

    logic [PG_W-1:0] act_lo_pg, act_hi_pg;
    logic            act_on;

    dpr_limit_ctrl #(
        .PG_W (PG_W),
        .SZ_W (SZ_W)
    ) u_limit (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_base_pg (cfg_base_pg),
        .cfg_size_pg (cfg_size_pg),
        .cfg_en      (cfg_en),
        .act_lo_pg   (act_lo_pg),
        .act_hi_pg   (act_hi_pg),
        .act_on      (act_on)
    );

    dpr_req_check #(
        .ADDR_W (ADDR_W),
        .PG_W   (PG_W)
    ) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_vld    (req_vld),
        .req_addr   (req_addr),
        .req_dma    (req_dma),
        .act_lo_pg  (act_lo_pg),
        .act_hi_pg  (act_hi_pg),
        .act_on     (act_on),
        .rsp_vld    (rsp_vld),
        .rsp_fault  (rsp_fault),
        .rsp_dram   (rsp_dram),
        .rsp_legacy (rsp_legacy)
    );

    AST_RESET_WINDOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !act_on); // R12

endmodule

// File: tb/dpr_guard_tb.sv
`timescale 1ns/1ps
module dpr_guard_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_vld = 1'b0;
    logic [19:0] req_addr = '0;
    logic        req_dma = 1'b0;
    logic [7:0]  cfg_base_pg = '0;
    logic [7:0]  cfg_size_pg = '0;
    logic        cfg_en = 1'b0;
    logic        rsp_vld, rsp_fault, rsp_dram, rsp_legacy;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dpr_guard #(.ADDR_W(20), .SZ_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_vld(req_vld), .req_addr(req_addr), .req_dma(req_dma),
        .cfg_base_pg(cfg_base_pg), .cfg_size_pg(cfg_size_pg), .cfg_en(cfg_en),
        .rsp_vld(rsp_vld), .rsp_fault(rsp_fault), .rsp_dram(rsp_dram),
        .rsp_legacy(rsp_legacy)
    );

    // Returns {fault, dram, legacy}
    function automatic logic [2:0] model(logic [19:0] a, bit d, int b, int s, bit e);
        int  pg = int'(a >> 12);
        bit  on = e && (s != 0);
        int  lo = on ? ((s > b) ? 0 : b - s) : b;
        bit  inw = on && (pg >= lo) && (pg < b);
        bit  leg = (a >= 20'hA0000) && (a <= 20'hBFFFF);
        return {d && inw, !leg && ((pg < lo) || (!d && inw)), leg};
    endfunction

    function automatic string tag_of(logic [19:0] a, bit d, int b, int s, bit e);
        int pg = int'(a >> 12);
        bit on = e && (s != 0);
        int lo = on ? ((s > b) ? 0 : b - s) : b;
        if ((a >= 20'hA0000) && (a <= 20'hBFFFF)) return "R5";
        if (pg >= b) return "R6";
        if (on && pg >= lo && d) return (s > b) ? "R8" : "R2";
        if (on && pg >= lo) return "R7";
        if (!on) return "R4";
        return "R3";
    endfunction

    task automatic chk(string tag, logic [3:0] got, logic [3:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got vld/fault/dram/leg=%b expected %b", tag, got, exp);
        end
    endtask

    function automatic logic [3:0] outs();
        return {rsp_vld, rsp_fault, rsp_dram, rsp_legacy};
    endfunction

    task automatic run_cfg(int b, int s, bit e);
        bit saw_cpu_fault = 1'b0;
        bit saw_overlap = 1'b0;
        cfg_base_pg = 8'(b);
        cfg_size_pg = 8'(s);
        cfg_en = e;
        req_vld = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 idle", outs(), 4'b0000);
        for (int p = 0; p < 256; p++) begin
            for (int d = 0; d < 2; d++) begin
                logic [19:0] a = {8'(p), (p % 2 == 1) ? 12'hFFF : 12'h000};
                logic [2:0]  ex = model(a, d[0], b, s, e);
                string       tg = tag_of(a, d[0], b, s, e);
                req_vld = 1'b1;
                req_addr = a;
                req_dma = d[0];
                @(negedge clk);
                if (d == 0 && rsp_fault) saw_cpu_fault = 1'b1;
                if (rsp_fault && rsp_dram) saw_overlap = 1'b1;
                chk(tg, outs(), {1'b1, ex});
            end
        end
        req_vld = 1'b0;
        @(negedge clk);
        chk("R1 processor fault seen", {3'b0, saw_cpu_fault}, 4'b0000);
        chk("R11 fault with dram seen", {3'b0, saw_overlap}, 4'b0000);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 in reset", outs(), 4'b0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 after reset", outs(), 4'b0000);

        // R9: an idle strobe with an in-window DMA address stays silent
        cfg_base_pg = 8'hF0; cfg_size_pg = 8'h10; cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        req_vld = 1'b0; req_addr = 20'hE8000; req_dma = 1'b1;
        @(negedge clk);
        chk("R9 invalid request", outs(), 4'b0000);

        run_cfg(8'hF0, 8'h10, 1'b1);
        run_cfg(8'h80, 8'h20, 1'b0);
        run_cfg(8'hC0, 8'h30, 1'b1);
        run_cfg(8'h20, 8'h40, 1'b1);
        run_cfg(8'hF0, 8'h00, 1'b1);
        run_cfg(8'hFF, 8'h01, 1'b1);

        // R10: grow the window while a DMA probe keeps issuing
        cfg_base_pg = 8'hF0; cfg_size_pg = 8'h10; cfg_en = 1'b1;
        repeat (3) @(negedge clk);
        begin
            logic [2:0] old_v = model(20'hD8000, 1'b1, 8'hF0, 8'h10, 1'b1);
            logic [2:0] new_v = model(20'hD8000, 1'b1, 8'hF0, 8'h20, 1'b1);
            req_vld = 1'b1; req_addr = 20'hD8000; req_dma = 1'b1;
            cfg_size_pg = 8'h20;
            for (int k = 0; k < 2; k++) begin
                @(negedge clk);
                n_cmp++;
                if (outs() !== {1'b1, old_v} && outs() !== {1'b1, new_v}) begin
                    n_bad++;
                    $display("FAIL R10 transition: got %b expected %b or %b",
                             outs(), {1'b1, old_v}, {1'b1, new_v});
                end
            end
            @(negedge clk);
            chk("R10 new limit in force", outs(), {1'b1, new_v});
            // Shrink back: the probe returns to DRAM
            cfg_size_pg = 8'h10;
            repeat (3) @(negedge clk);
            chk("R10 shrink in force", outs(), {1'b1, old_v});
        end
        req_vld = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule